// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the station-management master that sits on the MAC side of a two-wire PHY management bus. The host sets the PHY address, the register address, the operation (read or write) and the write data, then pulses `start` for one cycle. The block divides the system clock to produce MDC, shifts one complete management frame out on MDIO and hands the line to the PHY at the right bit times. On a read it collects the sixteen data bits the PHY returns.

An input selects whether the frame is preceded by the run of ones that wakes the PHY. The data pin is split into an output value, an output enable and an input, so the pad and the board pull-up stay outside the block. Each frame ends with one idle bit time in which the line is released. After that bit `busy` falls and `done` pulses. On a read, the captured word and a turnaround-error flag are updated at that same moment.

Top module: `mdio_master`

## Requirements
- R1: When `preamble_en` is 1 the frame opens with 32 bit times of MDIO driven to 1. When it is 0 the frame opens directly with the start field.
- R2: The start field is the two bits 0 then 1. The operation field follows: 1,0 for a read (`op_read`=1) and 0,1 for a write.
- R3: The 5-bit PHY address and then the 5-bit register address follow the operation field, each sent most significant bit first.
- R4: On a write the master drives 1 then 0 in the two turnaround bit times, then drives the 16 bits of `wdata`, most significant bit first.
- R5: MDC has a period of 2*HALF_DIV system clocks and rests low while idle. MDIO output and enable change only as MDC falls or at frame launch, so they are stable while MDC is high.
- R6: On a read, `mdio_oe` is 0 from the first turnaround bit through the last data bit. The 16 bits sampled on MDC rising edges appear on `rdata`, first received bit in bit 15.
- R7: On a read, `ta_err` is set to the value sampled in the second turnaround bit, so it is 1 exactly when the PHY failed to pull that bit to 0.
- R8: Every frame ends with one bit time in which `mdio_oe` is 0. `busy` is high from the cycle after `start` is accepted until that idle bit ends: 65*2*HALF_DIV cycles with the preamble and 33*2*HALF_DIV without it. `done` is a single-cycle pulse at the cycle `busy` falls.
- R9: A `start` pulse while `busy` is 1 is ignored. The fields are latched at acceptance, so later changes to the inputs leave the running frame unchanged.
- R10: `rdata` and `ta_err` change only in the cycle `done` is high, and only after a read. A write leaves both at their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to run a frame |
| op_read | input | 1 | 1 selects a read, 0 a write |
| preamble_en | input | 1 | 1 sends the 32-bit preamble |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wdata | input | 16 | Data for a write |
| mdio_i | input | 1 | Sampled MDIO line level |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value when driven |
| mdio_oe | output | 1 | MDIO drive enable |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Frame-complete pulse |
| rdata | output | 16 | Last read data |
| ta_err | output | 1 | Last read saw a nonzero second turnaround bit |

## Verification
The assertions assume `start` is a clean one-cycle pulse and that `mdio_i` does not change while MDC is high, which is how a PHY behaves when it updates its data after each rising edge. The bench's PHY model changes its drive only on MDC falling edges. It resolves the line from the master's enable, its own drive and a pull-up value of 1. Start pulses are issued only at falling system-clock edges.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        op_read,
  input  logic        preamble_en,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wdata,
  input  logic        mdio_i,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata,
  output logic        ta_err
);
  localparam int CW      = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int IDLE_B  = 64;
  localparam int TA_B    = 46;
  localparam int DATA_B  = 48;
  localparam int FIRST_B = 32;

  logic [CW-1:0] cnt;
  logic [6:0]    bitn;
  logic          rd_q;
  logic [4:0]    pa_q, ra_q;
  logic [15:0]   wd_q, shreg;
  logic          tabit_q;
  logic [63:0]   frame;
  logic          tick;

  assign tick  = (cnt == CW'(HALF_DIV - 1));
  assign frame = {32'hFFFF_FFFF, 2'b01, rd_q ? 2'b10 : 2'b01, pa_q, ra_q, 2'b10, wd_q};

  assign mdio_o  = (bitn < 7'(IDLE_B)) ? frame[~bitn[5:0]] : 1'b1;
  assign mdio_oe = busy && (bitn < 7'(IDLE_B)) && !(rd_q && bitn >= 7'(TA_B));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      bitn    <= 7'(IDLE_B);
      mdc     <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      rd_q    <= 1'b0;
      pa_q    <= '0;
      ra_q    <= '0;
      wd_q    <= '0;
      shreg   <= '0;
      tabit_q <= 1'b0;
      rdata   <= '0;
      ta_err  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          cnt  <= '0;
          mdc  <= 1'b0;
          bitn <= preamble_en ? 7'd0 : 7'(FIRST_B);
          rd_q <= op_read;
          pa_q <= phy_addr;
          ra_q <= reg_addr;
          wd_q <= wdata;
        end
      end else if (!tick) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        mdc <= ~mdc;
        if (!mdc) begin
          if (rd_q && bitn == 7'(TA_B + 1))
            tabit_q <= mdio_i;
          if (rd_q && bitn >= 7'(DATA_B) && bitn < 7'(IDLE_B))
            shreg <= {shreg[14:0], mdio_i};
        end else if (bitn == 7'(IDLE_B)) begin
          busy <= 1'b0;
          done <= 1'b1;
          if (rd_q) begin
            rdata  <= shreg;
            ta_err <= tabit_q;
          end
        end else begin
          bitn <= bitn + 7'd1;
        end
      end
    end
  end

  a_r5_mdc_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  a_r5_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  a_r8_done_at_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_fields_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable({rd_q, pa_q, ra_q, wd_q}));

  a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(rdata) && $stable(ta_err)));

endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic op_read = 1'b0;
  logic preamble_en = 1'b1;
  logic [4:0] phy_addr = '0;
  logic [4:0] reg_addr = '0;
  logic [15:0] wdata = '0;
  logic mdio_i;
  logic mdc, mdio_o, mdio_oe, busy, done, ta_err;
  logic [15:0] rdata;

  always #10 clk = ~clk;

  mdio_master #(.HALF_DIV(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_read(op_read),
    .preamble_en(preamble_en), .phy_addr(phy_addr), .reg_addr(reg_addr),
    .wdata(wdata), .mdio_i(mdio_i), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .busy(busy), .done(done), .rdata(rdata), .ta_err(ta_err)
  );

  int total = 0;
  int bad = 0;
  int cur_bit = 99;
  logic phy_rd = 1'b0;
  logic [15:0] phy_word = '0;
  logic phy_ta = 1'b0;
  logic phy_en, phy_val;
  logic rec_o [0:64];
  logic rec_oe [0:64];
  time t_prev = 0, t_last = 0;

  always_comb begin
    phy_en  = 1'b0;
    phy_val = 1'b1;
    if (phy_rd && cur_bit == 47) begin
      phy_en = 1'b1; phy_val = phy_ta;
    end else if (phy_rd && cur_bit >= 48 && cur_bit < 64) begin
      phy_en = 1'b1; phy_val = phy_word[63 - cur_bit];
    end
  end
  assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);

  always @(negedge mdc) cur_bit = cur_bit + 1;
  always @(posedge mdc) begin
    if (cur_bit >= 0 && cur_bit < 65) begin
      rec_o[cur_bit]  = mdio_o;
      rec_oe[cur_bit] = mdio_oe;
    end
    t_prev = t_last;
    t_last = $time;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // stimulus vectors: rd, pre, pa, ra, data (write data or PHY reply), ta_bad
  typedef struct packed {
    logic rd; logic pre; logic [4:0] pa; logic [4:0] ra; logic [15:0] d; logic tab;
  } vec_t;
  localparam vec_t VECS [0:5] = '{
    '{1'b0, 1'b1, 5'h01, 5'h00, 16'hA5C3, 1'b0},
    '{1'b1, 1'b1, 5'h1F, 5'h02, 16'h8001, 1'b0},
    '{1'b0, 1'b0, 5'h10, 5'h1F, 16'hFFFF, 1'b0},
    '{1'b1, 1'b0, 5'h00, 5'h15, 16'h0000, 1'b0},
    '{1'b1, 1'b1, 5'h0A, 5'h0B, 16'h1234, 1'b1},
    '{1'b0, 1'b1, 5'h15, 5'h0A, 16'h0001, 1'b0}
  };

  task automatic run(input vec_t v, input bit poke);
    logic [63:0] fr;
    int first, cyc;
    logic [15:0] rd_before;
    logic te_before;
    bit fok, eok;
    rd_before = rdata;
    te_before = ta_err;
    first = v.pre ? 0 : 32;
    for (int i = 0; i < 65; i++) begin rec_o[i] = 1'bx; rec_oe[i] = 1'bx; end
    phy_rd = v.rd; phy_word = v.d; phy_ta = v.tab;
    op_read = v.rd; preamble_en = v.pre; phy_addr = v.pa; reg_addr = v.ra;
    wdata = v.rd ? 16'h0 : v.d;
    cur_bit = first;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 1000) begin
      if (busy) cyc++;
      if (poke && cyc == 40) begin
        start = 1'b1; phy_addr = ~v.pa; op_read = ~v.rd; wdata = ~wdata;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    fr = {32'hFFFF_FFFF, 2'b01, v.rd ? 2'b10 : 2'b01, v.pa, v.ra, 2'b10, v.rd ? 16'h0 : v.d};
    fok = 1'b1; eok = 1'b1;
    for (int b = first; b < 64; b++) begin
      if (b < 46 || !v.rd) begin
        if (rec_o[b] !== fr[63 - b] || rec_oe[b] !== 1'b1) fok = 1'b0;
      end else if (rec_oe[b] !== 1'b0) eok = 1'b0;
    end
    check(fok, v.pre ? "R1 R2 R3 R4" : "R2 R3 R4", "driven frame bits", 0, 0);
    if (v.rd) check(eok, "R6", "line released in read window", 0, 0);
    check(rec_oe[64] === 1'b0, "R8", "idle bit released", rec_oe[64], 0);
    check(cyc == (64 - first + 1) * 2 * HALF, "R8", "busy length", cyc, (64 - first + 1) * 2 * HALF);
    check(t_last - t_prev == 2 * HALF * 20, "R5", "mdc period ns", t_last - t_prev, 2 * HALF * 20);
    if (poke) check(fok && cyc == (64 - first + 1) * 2 * HALF, "R9", "start while busy ignored", cyc, 0);
    @(negedge clk);
    if (v.rd) begin
      check(rdata === v.d, "R6", "rdata", rdata, v.d);
      check(ta_err === v.tab, "R7", "ta_err", ta_err, v.tab);
    end else begin
      check(rdata === rd_before && ta_err === te_before, "R10", "write keeps results",
            {rdata, ta_err}, {rd_before, te_before});
    end
    check(mdc === 1'b0 && busy === 1'b0 && done === 1'b0, "R5", "idle after frame", {mdc, busy, done}, 0);
    phy_rd = 1'b0;
    cur_bit = 99;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(mdc === 0 && busy === 0 && done === 0 && mdio_oe === 0 && rdata === 0 && ta_err === 0,
          "R8", "reset state", {mdc, busy, done, mdio_oe, rdata, ta_err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 6; k++) run(VECS[k], 1'b0);
    run('{1'b1, 1'b1, 5'h03, 5'h04, 16'hBEEF, 1'b0}, 1'b1);
    run('{1'b0, 1'b0, 5'h07, 5'h09, 16'h5A5A, 1'b0}, 1'b1);
    check(rdata === 16'hBEEF, "R9", "poked read result intact", rdata, 16'hBEEF);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule